// File: doc/BRIEF.md
# Periphery NAND/XNOR Tree Test Controller

This block puts a device periphery into a manufacturing connectivity test. At reset it captures a set of strap pins: a three-bit mode strap, a test-clock strap and two test-select straps. From these it picks one of three states: normal operation, NAND-tree test or XNOR-tree test. The choice is held until the next reset.

In either tree state, the input-buffer values of two ordered groups of peripheral pins feed two independent combinational chains. Each chain starts from its own seed input and ends on its own observation output. Chain A drives the interrupt output and chain B drives the test-out output. At the same time, every other output and bidirectional pad has its output enable forced off.

A tester toggles a seed or a single pin and watches the two observation outputs. This shows whether each input buffer is connected. There is no clocked stage on the path from a seed or a pin to its observation output. In normal operation the two observation outputs carry their functional signals, and the pad enables pass through unchanged.

Top module: `periph_tree_ctrl`

## Requirements
- R1: Straps mode=3'b111, test clock=0, select_a=0 and select_b=1, captured during reset, select NAND-tree test. `test_mode` then reads 2'd1.
- R2: Straps mode=3'b111, test clock=0, select_a=1 and select_b=0, captured during reset, select XNOR-tree test. `test_mode` then reads 2'd2.
- R3: Every other strap combination selects normal operation, and `test_mode` reads 2'd0. This includes mode 3'b111 with the test clock at 1, and mode 3'b111 with both selects at 0 or both at 1.
- R4: The straps are captured on every rising clock edge while `rst` is high. From the first edge with `rst` low, the captured mode is held and later strap changes have no effect until `rst` is asserted again.
- R5: NAND chain. Stage 0 is the seed. Stage k is NOT(stage k-1 AND pin k). Pin vector bit 0 is chain element 1, the farthest from the output. The chain output is the last stage.
- R6: XNOR chain. The stages follow the same order, with stage k = NOT(stage k-1 XOR pin k). As a result, any single-pin or seed toggle toggles the chain output.
- R7: In either tree state, `irq_out` carries the chain A output and `tout_out` carries the chain B output. Both follow their seed and pins combinationally, within the same clock cycle.
- R8: In either tree state, every bit of `pad_oe` is 0, whatever `func_oe` holds.
- R9: In normal operation, `irq_out` equals `func_irq`, `tout_out` equals `func_tout`, and `pad_oe` equals `func_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for strap capture |
| rst | input | 1 | Synchronous active-high reset; straps are captured while high |
| strap_mode | input | 3 | Mode strap |
| strap_tclk | input | 1 | Test-clock strap |
| strap_sel_a | input | 1 | First test-select strap |
| strap_sel_b | input | 1 | Second test-select strap |
| seed_a | input | 1 | Seed of chain A |
| seed_b | input | 1 | Seed of chain B |
| pins_a | input | LEN_A | Input-buffer values of chain A, bit 0 farthest from the output |
| pins_b | input | LEN_B | Input-buffer values of chain B, bit 0 farthest from the output |
| func_irq | input | 1 | Functional interrupt level |
| func_tout | input | 1 | Functional test-out level |
| func_oe | input | NUM_PADS | Functional output enables of the other pads |
| irq_out | output | 1 | Interrupt pin value / chain A observation |
| tout_out | output | 1 | Test-out pin value / chain B observation |
| pad_oe | output | NUM_PADS | Final output enables of the other pads |
| test_mode | output | 2 | Held mode: 0 normal, 1 NAND tree, 2 XNOR tree |

## Verification
The bench builds the block with LEN_A=5, LEN_B=4 and NUM_PADS=6. Because one chain length is odd and the other even, both parities of the inversion count along a chain are covered. The short chains also let the bench sweep every single-pin toggle in both tree states against its own stage-by-stage model. It also sweeps all 32 patterns of chain A, so every stage sees both of its inputs at both values. The straps are changed right after reset release to show that the captured mode holds.

// File: rtl/periph_tree_pkg.sv
package periph_tree_pkg;

    typedef enum logic [1:0] {
        TM_NORMAL = 2'd0,
        TM_NAND   = 2'd1,
        TM_XNOR   = 2'd2
    } tree_mode_e;

    typedef struct packed {
        logic [2:0] mode;
        logic       tclk;
        logic       sel_a;
        logic       sel_b;
    } strap_t;

    localparam logic [2:0] TREE_MODE_CODE = 3'b111;

    function automatic tree_mode_e decode_straps(input strap_t s);
        tree_mode_e m;
        m = TM_NORMAL;
        if (s.mode == TREE_MODE_CODE && !s.tclk) begin
            if (!s.sel_a && s.sel_b)
                m = TM_NAND;
            else if (s.sel_a && !s.sel_b)
                m = TM_XNOR;
        end
        return m;
    endfunction

    function automatic logic tree_cell(input logic prev, input logic pin,
                                       input logic use_xnor);
        return use_xnor ? ~(prev ^ pin) : ~(prev & pin);
    endfunction

endpackage

// File: rtl/strap_capture.sv
module strap_capture
    import periph_tree_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  strap_t     straps,
    output tree_mode_e mode_q
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= decode_straps(straps);
    end

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> $stable(mode_q));

    // R3
    mode_legal_chk: assert property (@(posedge clk) disable iff (rst)
        mode_q != tree_mode_e'(2'd3));

endmodule

// File: rtl/tree_chain.sv
module tree_chain
    import periph_tree_pkg::*;
#(
    parameter int LEN = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           use_xnor,
    input  logic           seed,
    input  logic [LEN-1:0] pins,
    output logic           tap
);

    localparam logic LEN_ODD = LEN[0];

    logic [LEN:0] stage;

    assign stage[0] = seed;

    generate
        for (genvar k = 0; k < LEN; k++) begin : g_cell
            assign stage[k+1] = tree_cell(stage[k], pins[k], use_xnor);
        end
    endgenerate

    assign tap = stage[LEN];

    // R6
    xnor_parity_chk: assert property (@(posedge clk) disable iff (rst)
        use_xnor |-> (tap == (seed ^ (^pins) ^ LEN_ODD)));

    // R5
    nand_all_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (!use_xnor && (&pins)) |-> (tap == (seed ^ LEN_ODD)));

endmodule

// File: rtl/pad_override.sv
module pad_override
    import periph_tree_pkg::*;
#(
    parameter int NUM_PADS = 8
) (
    input  tree_mode_e          mode,
    input  logic                tap_a,
    input  logic                tap_b,
    input  logic                func_irq,
    input  logic                func_tout,
    input  logic [NUM_PADS-1:0] func_oe,
    output logic                irq_out,
    output logic                tout_out,
    output logic [NUM_PADS-1:0] pad_oe
);

    logic tree_on;

    always_comb begin
        tree_on = (mode == TM_NAND) || (mode == TM_XNOR);
        if (tree_on) begin
            irq_out  = tap_a;
            tout_out = tap_b;
            pad_oe   = '0;
        end else begin
            irq_out  = func_irq;
            tout_out = func_tout;
            pad_oe   = func_oe;
        end
    end

endmodule

// File: rtl/periph_tree_ctrl.sv
module periph_tree_ctrl
    import periph_tree_pkg::*;
#(
    parameter int LEN_A    = 24,
    parameter int LEN_B    = 20,
    parameter int NUM_PADS = 48
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          strap_mode,
    input  logic                strap_tclk,
    input  logic                strap_sel_a,
    input  logic                strap_sel_b,
    input  logic                seed_a,
    input  logic                seed_b,
    input  logic [LEN_A-1:0]    pins_a,
    input  logic [LEN_B-1:0]    pins_b,
    input  logic                func_irq,
    input  logic                func_tout,
    input  logic [NUM_PADS-1:0] func_oe,
    output logic                irq_out,
    output logic                tout_out,
    output logic [NUM_PADS-1:0] pad_oe,
    output logic [1:0]          test_mode
);

    strap_t     straps;
    tree_mode_e mode_q;
    logic       use_xnor;
    logic       tap_a;
    logic       tap_b;

    assign straps = '{mode: strap_mode, tclk: strap_tclk,
                      sel_a: strap_sel_a, sel_b: strap_sel_b};

    strap_capture u_straps (
        .clk    (clk),
        .rst    (rst),
        .straps (straps),
        .mode_q (mode_q)
    );

    assign use_xnor = (mode_q == TM_XNOR);

    tree_chain #(.LEN(LEN_A)) u_chain_a (
        .clk      (clk),
        .rst      (rst),
        .use_xnor (use_xnor),
        .seed     (seed_a),
        .pins     (pins_a),
        .tap      (tap_a)
    );

    tree_chain #(.LEN(LEN_B)) u_chain_b (
        .clk      (clk),
        .rst      (rst),
        .use_xnor (use_xnor),
        .seed     (seed_b),
        .pins     (pins_b),
        .tap      (tap_b)
    );

    pad_override #(.NUM_PADS(NUM_PADS)) u_pads (
        .mode      (mode_q),
        .tap_a     (tap_a),
        .tap_b     (tap_b),
        .func_irq  (func_irq),
        .func_tout (func_tout),
        .func_oe   (func_oe),
        .irq_out   (irq_out),
        .tout_out  (tout_out),
        .pad_oe    (pad_oe)
    );

    assign test_mode = mode_q;

    // R8
    tree_pads_off_chk: assert property (@(posedge clk) disable iff (rst)
        (test_mode != 2'd0) |-> (pad_oe == '0));

    // R9
    normal_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (test_mode == 2'd0) |-> (irq_out == func_irq && tout_out == func_tout
                                 && pad_oe == func_oe));

    // R7
    tree_observe_chk: assert property (@(posedge clk) disable iff (rst)
        (test_mode != 2'd0) |-> (irq_out == tap_a && tout_out == tap_b));

endmodule

// File: tb/sim_periph_tree_ctrl.sv
module sim_periph_tree_ctrl;

    localparam int LA = 5;
    localparam int LB = 4;
    localparam int NP = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [2:0]    strap_mode = 3'b000;
    logic          strap_tclk = 1'b0;
    logic          strap_sel_a = 1'b0;
    logic          strap_sel_b = 1'b0;
    logic          seed_a = 1'b0;
    logic          seed_b = 1'b0;
    logic [LA-1:0] pins_a = '1;
    logic [LB-1:0] pins_b = '1;
    logic          func_irq = 1'b0;
    logic          func_tout = 1'b0;
    logic [NP-1:0] func_oe = '0;
    logic          irq_out;
    logic          tout_out;
    logic [NP-1:0] pad_oe;
    logic [1:0]    test_mode;

    int checks = 0;
    int errors = 0;
    int exp_mode = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    periph_tree_ctrl #(.LEN_A(LA), .LEN_B(LB), .NUM_PADS(NP)) u0 (
        .clk(clk), .rst(rst),
        .strap_mode(strap_mode), .strap_tclk(strap_tclk),
        .strap_sel_a(strap_sel_a), .strap_sel_b(strap_sel_b),
        .seed_a(seed_a), .seed_b(seed_b), .pins_a(pins_a), .pins_b(pins_b),
        .func_irq(func_irq), .func_tout(func_tout), .func_oe(func_oe),
        .irq_out(irq_out), .tout_out(tout_out), .pad_oe(pad_oe),
        .test_mode(test_mode)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_mode(input logic [2:0] m, input logic tc,
                                      input logic a, input logic b);
        if (m != 3'b111 || tc) return 0;
        if (a == 1'b0 && b == 1'b1) return 1;
        if (a == 1'b1 && b == 1'b0) return 2;
        return 0;
    endfunction

    function automatic logic model_tree(input logic s, input logic [15:0] p,
                                        input int n, input bit xnor_op);
        logic v = s;
        for (int i = 0; i < n; i++) begin
            if (xnor_op) v = (v == p[i]);
            else         v = !(v && p[i]);
        end
        return v;
    endfunction

    task automatic compare();
        logic exp_irq, exp_tout;
        logic [NP-1:0] exp_oe;
        string rq;
        if (exp_mode == 0) begin
            exp_irq = func_irq; exp_tout = func_tout; exp_oe = func_oe;
            chk("R9", "irq_out", 32'(irq_out), 32'(exp_irq));
            chk("R9", "tout_out", 32'(tout_out), 32'(exp_tout));
            chk("R9", "pad_oe", 32'(pad_oe), 32'(exp_oe));
        end else begin
            rq = (exp_mode == 1) ? "R5/R7" : "R6/R7";
            exp_irq  = model_tree(seed_a, 16'(pins_a), LA, exp_mode == 2);
            exp_tout = model_tree(seed_b, 16'(pins_b), LB, exp_mode == 2);
            chk(rq, "irq_out chain A", 32'(irq_out), 32'(exp_irq));
            chk(rq, "tout_out chain B", 32'(tout_out), 32'(exp_tout));
            chk("R8", "pad_oe", 32'(pad_oe), 32'(0));
        end
    endtask

    task automatic start(input logic [2:0] m, input logic tc,
                         input logic a, input logic b, input string req);
        @(posedge clk); #1;
        strap_mode = m; strap_tclk = tc; strap_sel_a = a; strap_sel_b = b;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
        exp_mode = model_mode(m, tc, a, b);
        // R4: scramble straps right after release; mode must not move
        strap_mode = ~m; strap_tclk = ~tc; strap_sel_a = b; strap_sel_b = a;
        @(negedge clk);
        chk(req, "test_mode after reset", 32'(test_mode), 32'(exp_mode));
        repeat (3) @(negedge clk);
        chk("R4", "test_mode held", 32'(test_mode), 32'(exp_mode));
    endtask

    task automatic apply(input logic sa, input logic sb, input logic [LA-1:0] pa,
                         input logic [LB-1:0] pb, input logic fi, input logic ft,
                         input logic [NP-1:0] fo);
        @(posedge clk); #1;
        seed_a = sa; seed_b = sb; pins_a = pa; pins_b = pb;
        func_irq = fi; func_tout = ft; func_oe = fo;
        @(negedge clk);
        compare();
    endtask

    task automatic sweep_tree();
        for (int s = 0; s < 2; s++) begin
            apply(s[0], s[0], '1, '1, 1'b1, 1'b1, '1);
            for (int i = 0; i < LA; i++) begin
                logic [LA-1:0] pa = '1;
                logic [LB-1:0] pb = '1;
                pa[i] = 1'b0;
                if (i < LB) pb[i] = 1'b0;
                apply(s[0], !s[0], pa, pb, 1'b0, 1'b1, NP'(6'h2a));
            end
        end
        for (int v = 0; v < 32; v++)
            apply(v[1], v[2], LA'(v), LB'(v >> 1), v[0], v[3], '1);
    endtask

    initial begin
        start(3'b000, 1'b0, 1'b0, 1'b0, "R3");
        apply(1'b0, 1'b0, '1, '1, 1'b1, 1'b0, NP'(6'h15));
        apply(1'b1, 1'b1, '0, '0, 1'b0, 1'b1, NP'(6'h3f));

        start(3'b111, 1'b0, 1'b0, 1'b1, "R1");
        sweep_tree();

        start(3'b111, 1'b0, 1'b1, 1'b0, "R2");
        sweep_tree();

        start(3'b111, 1'b1, 1'b0, 1'b1, "R3");
        apply(1'b1, 1'b0, '1, '1, 1'b1, 1'b0, NP'(6'h0f));
        start(3'b111, 1'b0, 1'b0, 1'b0, "R3");
        apply(1'b1, 1'b0, '1, '1, 1'b0, 1'b1, NP'(6'h30));
        start(3'b111, 1'b0, 1'b1, 1'b1, "R3");
        apply(1'b0, 1'b1, '0, '1, 1'b1, 1'b1, NP'(6'h21));
        start(3'b011, 1'b0, 1'b0, 1'b1, "R3");
        apply(1'b0, 1'b1, '1, '0, 1'b0, 1'b0, NP'(6'h3f));
        start(3'b110, 1'b0, 1'b1, 1'b0, "R3");
        apply(1'b1, 1'b1, '1, '1, 1'b1, 1'b0, NP'(6'h01));

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule